// File: doc/BRIEF.md
# Host Bus Bridge with Per-Access Byte Order and FIFO Steering

The bridge is the slave end of a 32-bit asynchronous, SRAM-style host port. An external processor drives an active-low chip select, active-low read and write strobes, a byte address and write data. The bridge turns each access into one request on simple internal ports that run on the core clock. Those ports are a register bank port, a transmit-data push port and a receive-data pop port. The internal data paths are 32-bit little endian.

Two sideband inputs are sampled with every access. `hst_big_end` selects the byte order of that access alone. A board can therefore wire it to a high address line and mix byte orders across register and data traffic. `hst_fifo_sel` sends the access straight to the data FIFOs and skips the address decoder. This lets a DMA engine that can only walk addresses stream packet data. The host strobes cross into the core clock through synchronisers. An access starts on the synchronised falling edge of a strobe.

Top module: `host_bus_bridge`

## Requirements
- R1: After reset, no internal pulse is issued, both sticky error flags read 0 and the held read data is 0.
- R2: Each host strobe, whether held low for 1 cycle or for 20 cycles, produces exactly one internal pulse. The pulse lasts one core clock cycle.
- R3: With `hst_big_end` low, write data reaches the internal ports unchanged. Read data reaches the host bus unchanged.
- R4: With `hst_big_end` high, the four bytes are reversed in both directions: host bits [7:0] pair with internal bits [31:24], and so on.
- R5: The byte order is taken per access. Consecutive accesses with different `hst_big_end` values are each converted by their own setting.
- R6: With `hst_fifo_sel` high, a write pushes to the transmit FIFO and a read pops the receive FIFO, whatever the address.
- R7: With `hst_fifo_sel` low, the word index `hst_addr[7:2]` is decoded as follows. Index 0 is the FIFO data port, where a write pushes and a read pops. Index 1 is the error-flag word, with bit 0 for receive underrun and bit 1 for transmit overrun. Writing a 1 to a bit of the error-flag word clears that flag. Indices 16 to 31 are register-bank entries `reg_addr` = index − 16.
- R8: An unmapped index in normal mode returns 0x00000000 on a read. A write to it issues no internal pulse.
- R9: A pop request while `rx_empty` is high issues no `rx_pop`, returns 0 and sets `err_rx_under` until it is cleared.
- R10: A push request while `tx_full` is high issues no `tx_push` and sets `err_tx_over` until it is cleared.
- R11: `hst_rdata_oe` is high exactly while chip select and the read strobe are both low. `hst_rdata` is 0 whenever it is not driven. The read data is held until the next read completes.
- R12: If the read and write strobes are seen falling in the same synchronised cycle, the write is served and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs_n | input | 1 | Host chip select, active low, asynchronous |
| hst_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| hst_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| hst_addr | input | ADDR_W | Host byte address |
| hst_wdata | input | DATA_W | Host write data |
| hst_big_end | input | 1 | Byte order of this access (1 = big endian) |
| hst_fifo_sel | input | 1 | Forces this access to the data FIFOs |
| hst_rdata | output | DATA_W | Host read data, 0 when not driven |
| hst_rdata_oe | output | 1 | Drive enable for the host data bus |
| tx_push | output | 1 | One-cycle push into the transmit FIFO |
| tx_data | output | DATA_W | Push data, little endian |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | One-cycle pop of the receive FIFO |
| rx_data | input | DATA_W | Head word of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| reg_wr | output | 1 | One-cycle register write |
| reg_rd | output | 1 | One-cycle register read |
| reg_addr | output | REG_AW | Register-bank entry |
| reg_wdata | output | DATA_W | Register write data, little endian |
| reg_rdata | input | DATA_W | Register read data, valid in the `reg_rd` cycle |
| err_rx_under | output | 1 | Sticky receive underrun flag |
| err_tx_over | output | 1 | Sticky transmit overrun flag |

## Verification
A host can let the read and the write strobe fall together. Both edges then reach the synchronised domain in the same core cycle, and both a push and a pop could be issued at once. The bench provokes this by lowering both strobes in the same drive step, with `hst_fifo_sel` high and receive data available. The per-clock reference model expects exactly one transmit push carrying the write data, no receive pop, and an unchanged receive queue. The one-hot assertion on the four request pulses guards the same case continuously.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    // Fixed word indices of the normal-mode decode
    localparam int unsigned DATA_PORT_IDX = 0;
    localparam int unsigned FLAG_WORD_IDX = 1;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_TX_PUSH = 3'd1,
        ACT_RX_POP  = 3'd2,
        ACT_REG_WR  = 3'd3,
        ACT_REG_RD  = 3'd4,
        ACT_FLAG_WR = 3'd5,
        ACT_FLAG_RD = 3'd6,
        ACT_NULL_RD = 3'd7
    } act_e;

endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] fall_o
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end

        // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
        assign level_o[b] = sh_q[STAGES-1];
        assign fall_o[b]  = sh_q[STAGES] & ~sh_q[STAGES-1];
    end

endmodule

// File: rtl/hbus_byte_lane.sv
module hbus_byte_lane #(
    parameter  int DATA_W = 32,
    localparam int NB     = DATA_W / 8
) (
    input  logic              big_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign data_o[8*k +: 8] = big_i ? data_i[8*(NB-1-k) +: 8] : data_i[8*k +: 8];
    end

endmodule

// File: rtl/hbus_addr_decode.sv
module hbus_addr_decode
    import hbus_pkg::*;
#(
    parameter  int ADDR_W       = 8,
    parameter  int NUM_REGS     = 16,
    parameter  int REG_BASE_IDX = 16,
    localparam int IDX_W        = ADDR_W - 2,
    localparam int REG_AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              fifo_mode_i,
    input  logic              is_write_i,
    input  logic [IDX_W-1:0]  word_idx_i,
    output act_e              act_o,
    output logic [REG_AW-1:0] reg_idx_o
);

    logic [31:0] idx32;
    logic [31:0] rel32;

    assign idx32 = 32'(word_idx_i);
    assign rel32 = idx32 - 32'(REG_BASE_IDX);

    always_comb begin
        reg_idx_o = rel32[REG_AW-1:0];
        if (fifo_mode_i || idx32 == 32'(DATA_PORT_IDX)) begin
            act_o = is_write_i ? ACT_TX_PUSH : ACT_RX_POP;
        end else if (idx32 == 32'(FLAG_WORD_IDX)) begin
            act_o = is_write_i ? ACT_FLAG_WR : ACT_FLAG_RD;
        end else if (idx32 >= 32'(REG_BASE_IDX) && rel32 < 32'(NUM_REGS)) begin
            act_o = is_write_i ? ACT_REG_WR : ACT_REG_RD;
        end else begin
            act_o = is_write_i ? ACT_NONE : ACT_NULL_RD;
        end
    end

endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
    import hbus_pkg::*;
#(
    parameter  int ADDR_W       = 8,
    parameter  int DATA_W       = 32,
    parameter  int NUM_REGS     = 16,
    parameter  int REG_BASE_IDX = 16,
    parameter  int SYNC_STAGES  = 2,
    localparam int REG_AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_cs_n,
    input  logic              hst_wr_n,
    input  logic              hst_rd_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              hst_big_end,
    input  logic              hst_fifo_sel,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_rdata_oe,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              err_rx_under,
    output logic              err_tx_over
);

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic              req_vld;
        act_e              act;
        logic              big;
        logic [REG_AW-1:0] ridx;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic              under;
        logic              over;
    } st_t;

    st_t st_d, st_q;

    // Strobe synchroniser: bit 0 chip select, bit 1 write, bit 2 read
    logic [2:0] sy_lvl, sy_fall;
    logic       fall_wr, fall_rd;

    hbus_strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hst_rd_n, hst_wr_n, hst_cs_n}),
        .level_o (sy_lvl),
        .fall_o  (sy_fall)
    );

    assign fall_wr = sy_fall[1] & ~sy_lvl[0];
    assign fall_rd = sy_fall[2] & ~sy_lvl[0];

    // Address decode; a simultaneous write edge wins over a read edge
    act_e              dec_act;
    logic [REG_AW-1:0] dec_ridx;

    hbus_addr_decode #(
        .ADDR_W       (ADDR_W),
        .NUM_REGS     (NUM_REGS),
        .REG_BASE_IDX (REG_BASE_IDX)
    ) u_dec (
        .fifo_mode_i (hst_fifo_sel),
        .is_write_i  (fall_wr),
        .word_idx_i  (hst_addr[ADDR_W-1:2]),
        .act_o       (dec_act),
        .reg_idx_o   (dec_ridx)
    );

    logic unused_addr_lsb;
    assign unused_addr_lsb = ^hst_addr[1:0];

    // Inbound byte lanes
    logic [DATA_W-1:0] wr_int;

    hbus_byte_lane #(.DATA_W(DATA_W)) u_wlane (
        .big_i  (hst_big_end),
        .data_i (hst_wdata),
        .data_o (wr_int)
    );

    // Outbound response and byte lanes
    logic [DATA_W-1:0] resp_int, resp_host;

    always_comb begin
        resp_int = '0;
        case (st_q.act)
            ACT_RX_POP:  resp_int = rx_data;
            ACT_REG_RD:  resp_int = reg_rdata;
            ACT_FLAG_RD: resp_int = {{(DATA_W-2){1'b0}}, st_q.over, st_q.under};
            default:     resp_int = '0;
        endcase
    end

    hbus_byte_lane #(.DATA_W(DATA_W)) u_rlane (
        .big_i  (st_q.big),
        .data_i (resp_int),
        .data_o (resp_host)
    );

    // Next state
    always_comb begin
        st_d         = st_q;
        st_d.req_vld = 1'b0;

        if (st_q.req_vld) begin
            case (st_q.act)
                ACT_TX_PUSH: begin
                    if (tx_full) st_d.over = 1'b1;
                end
                ACT_RX_POP: begin
                    if (rx_empty) begin
                        st_d.under = 1'b1;
                        st_d.rdat  = '0;
                    end else begin
                        st_d.rdat  = resp_host;
                    end
                end
                ACT_REG_RD, ACT_FLAG_RD, ACT_NULL_RD: begin
                    st_d.rdat = resp_host;
                end
                ACT_FLAG_WR: begin
                    st_d.under = st_q.under & ~st_q.wdat[0];
                    st_d.over  = st_q.over  & ~st_q.wdat[1];
                end
                default: ;
            endcase
        end

        if (fall_wr || fall_rd) begin
            st_d.req_vld = 1'b1;
            st_d.act     = dec_act;
            st_d.big     = hst_big_end;
            st_d.ridx    = dec_ridx;
            st_d.wdat    = wr_int;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Internal request ports
    assign tx_push   = st_q.req_vld && (st_q.act == ACT_TX_PUSH) && !tx_full;
    assign rx_pop    = st_q.req_vld && (st_q.act == ACT_RX_POP)  && !rx_empty;
    assign reg_wr    = st_q.req_vld && (st_q.act == ACT_REG_WR);
    assign reg_rd    = st_q.req_vld && (st_q.act == ACT_REG_RD);
    assign reg_addr  = st_q.ridx;
    assign reg_wdata = st_q.wdat;
    assign tx_data   = st_q.wdat;

    assign err_rx_under = st_q.under;
    assign err_tx_over  = st_q.over;

    // Host data bus
    assign hst_rdata_oe = !hst_cs_n && !hst_rd_n;
    assign hst_rdata    = hst_rdata_oe ? st_q.rdat : '0;

endmodule

// File: rtl/hbus_checker.sv
module hbus_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_push,
    input logic tx_full,
    input logic rx_pop,
    input logic rx_empty,
    input logic reg_wr,
    input logic reg_rd,
    input logic err_rx_under,
    input logic err_tx_over
);

    // R2: every internal request is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push || rx_pop || reg_wr || reg_rd) |=> !(tx_push || rx_pop || reg_wr || reg_rd));

    // R12: at most one internal request at a time
    a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push, rx_pop, reg_wr, reg_rd}));

    // R9: never pop an empty receive FIFO
    a_r9_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    // R10: never push a full transmit FIFO
    a_r10_no_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    // R9: underrun flag only rises after an empty receive FIFO was seen
    a_r9_under_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_rx_under) |-> $past(rx_empty));

    // R10: overrun flag only rises after a full transmit FIFO was seen
    a_r10_over_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tx_over) |-> $past(tx_full));

endmodule

bind host_bus_bridge hbus_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_push      (tx_push),
    .tx_full      (tx_full),
    .rx_pop       (rx_pop),
    .rx_empty     (rx_empty),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .err_rx_under (err_rx_under),
    .err_tx_over  (err_tx_over)
);

// File: tb/host_bus_bridge_bench.sv
`timescale 1ns/1ps
module host_bus_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_cs_n = 1'b1, hst_wr_n = 1'b1, hst_rd_n = 1'b1;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_big_end = 1'b0, hst_fifo_sel = 1'b0;
    logic [31:0] hst_rdata;
    logic        hst_rdata_oe;
    logic        tx_push;
    logic [31:0] tx_data;
    logic        tx_full = 1'b0;
    logic        rx_pop;
    logic [31:0] rx_data = '0;
    logic        rx_empty = 1'b1;
    logic        reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        err_rx_under, err_tx_over;

    always #2.5 clk = ~clk;

    host_bus_bridge u_host_bus_bridge (
        .clk(clk), .rst_n(rst_n),
        .hst_cs_n(hst_cs_n), .hst_wr_n(hst_wr_n), .hst_rd_n(hst_rd_n),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_big_end(hst_big_end), .hst_fifo_sel(hst_fifo_sel),
        .hst_rdata(hst_rdata), .hst_rdata_oe(hst_rdata_oe),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_rx_under(err_rx_under), .err_tx_over(err_tx_over)
    );

    // Bench register bank: a fixed pattern per entry
    function automatic logic [31:0] bank_word(input logic [3:0] i);
        return {8'hC3, 4'h0, i, 8'h5A, ~{4'h0, i}};
    endfunction
    assign reg_rdata = bank_word(reg_addr);

    function automatic logic [31:0] flip(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    int    checks = 0, errors = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Receive FIFO model
    logic [31:0] rxq[$];
    bit          pop_pend = 1'b0;

    task automatic rx_refresh();
        rx_empty = (rxq.size() == 0);
        rx_data  = (rxq.size() == 0) ? 32'h0 : rxq[0];
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            if (pop_pend) begin
                if (rxq.size() > 0) void'(rxq.pop_front());
                pop_pend = 1'b0;
                rx_refresh();
            end
        end
    end

    // Observation counters
    int          n_tx = 0, n_rx = 0, n_rw = 0, n_rr = 0;
    logic [31:0] last_tx = '0, last_rw = '0;
    logic [3:0]  last_ra = '0;

    // Cycle-by-cycle reference model
    typedef struct packed {
        logic        cs, rd, wr;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        be, fs;
    } snap_t;

    snap_t       hist[$];
    logic [31:0] m_rdat = '0;
    logic        m_under = 1'b0, m_over = 1'b0;
    bit          pend_rd = 1'b0, pend_set_u = 1'b0, pend_set_o = 1'b0, pend_clr = 1'b0;
    logic [31:0] pend_rdat = '0;
    logic [1:0]  pend_mask = '0;

    initial begin
        for (int i = 0; i < 6; i++) hist.push_back('{cs:1'b1, rd:1'b1, wr:1'b1, addr:8'h0, wd:32'h0, be:1'b0, fs:1'b0});
    end

    always @(negedge clk) begin
        snap_t s, p4, p3, p1;
        int n, idx, kind;
        bit wf, rf, e_tx, e_rp, e_rw, e_rr;
        logic [31:0] din, val;
        logic [3:0] e_ra;
        s = '{cs:hst_cs_n, rd:hst_rd_n, wr:hst_wr_n, addr:hst_addr, wd:hst_wdata, be:hst_big_end, fs:hst_fifo_sel};
        hist.push_back(s);
        if (hist.size() > 8) void'(hist.pop_front());
        n = hist.size();
        e_tx = 0; e_rp = 0; e_rw = 0; e_rr = 0; e_ra = '0; din = '0;

        if (tx_push) begin n_tx++; last_tx = tx_data; end
        if (rx_pop)  begin n_rx++; pop_pend = 1'b1; end
        if (reg_wr)  begin n_rw++; last_rw = reg_wdata; last_ra = reg_addr; end
        if (reg_rd)  n_rr++;

        if (!rst_n) begin
            m_rdat = '0; m_under = 0; m_over = 0;
            pend_rd = 0; pend_set_u = 0; pend_set_o = 0; pend_clr = 0;
        end else begin
            if (pend_rd)    m_rdat = pend_rdat;
            if (pend_set_u) m_under = 1'b1;
            if (pend_set_o) m_over = 1'b1;
            if (pend_clr) begin
                m_under = m_under & ~pend_mask[0];
                m_over  = m_over  & ~pend_mask[1];
            end
            pend_rd = 0; pend_set_u = 0; pend_set_o = 0; pend_clr = 0;

            p4 = hist[n-5]; p3 = hist[n-4]; p1 = hist[n-2];
            wf = p4.wr && !p3.wr && !p3.cs;
            rf = p4.rd && !p3.rd && !p3.cs;
            if (wf || rf) begin
                idx  = int'(p1.addr[7:2]);
                kind = (p1.fs || idx == 0) ? 0 : (idx == 1) ? 1 : (idx >= 16 && idx < 32) ? 2 : 3;
                din  = p1.be ? flip(p1.wd) : p1.wd;
                e_ra = 4'(idx - 16);
                if (wf) begin
                    if (kind == 0) begin
                        if (tx_full) pend_set_o = 1; else e_tx = 1;
                    end else if (kind == 1) begin
                        pend_clr = 1; pend_mask = din[1:0];
                    end else if (kind == 2) begin
                        e_rw = 1;
                    end
                end else begin
                    val = '0;
                    if (kind == 0) begin
                        if (rx_empty) pend_set_u = 1; else begin e_rp = 1; val = rx_data; end
                    end else if (kind == 1) begin
                        val = {30'h0, m_over, m_under};
                    end else if (kind == 2) begin
                        e_rr = 1; val = bank_word(e_ra);
                    end
                    pend_rd = 1; pend_rdat = p1.be ? flip(val) : val;
                end
            end
        end

        chk(tx_push == e_tx, {cur_tag, " R2 tx_push"}, 32'(tx_push), 32'(e_tx));
        chk(rx_pop == e_rp, {cur_tag, " R2 rx_pop"}, 32'(rx_pop), 32'(e_rp));
        chk(reg_wr == e_rw, {cur_tag, " R2 reg_wr"}, 32'(reg_wr), 32'(e_rw));
        chk(reg_rd == e_rr, {cur_tag, " R2 reg_rd"}, 32'(reg_rd), 32'(e_rr));
        if (e_tx) chk(tx_data == din, {cur_tag, " tx_data"}, tx_data, din);
        if (e_rw) begin
            chk(reg_wdata == din, {cur_tag, " reg_wdata"}, reg_wdata, din);
            chk(reg_addr == e_ra, {cur_tag, " R7 reg_addr"}, 32'(reg_addr), 32'(e_ra));
        end
        if (e_rr) chk(reg_addr == e_ra, {cur_tag, " R7 reg_addr"}, 32'(reg_addr), 32'(e_ra));
        chk(err_rx_under == m_under, {cur_tag, " R9 under"}, 32'(err_rx_under), 32'(m_under));
        chk(err_tx_over == m_over, {cur_tag, " R10 over"}, 32'(err_tx_over), 32'(m_over));
        chk(hst_rdata_oe == (!hst_cs_n && !hst_rd_n), {cur_tag, " R11 oe"},
            32'(hst_rdata_oe), 32'(!hst_cs_n && !hst_rd_n));
        chk(hst_rdata == ((!hst_cs_n && !hst_rd_n) ? m_rdat : 32'h0), {cur_tag, " R11 rdata"},
            hst_rdata, (!hst_cs_n && !hst_rd_n) ? m_rdat : 32'h0);
    end

    // One host access; rv is the bus value just before the strobe rises
    task automatic access(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d,
                          input bit be, input bit fs, input int hold, output logic [31:0] rv);
        @(posedge clk); #1;
        hst_addr = a; hst_wdata = d; hst_big_end = be; hst_fifo_sel = fs; hst_cs_n = 1'b0;
        @(posedge clk); #1;
        hst_wr_n = !wr; hst_rd_n = !rd;
        repeat (hold - 1) @(posedge clk);
        @(negedge clk); rv = hst_rdata;
        @(posedge clk); #1;
        hst_wr_n = 1'b1; hst_rd_n = 1'b1;
        repeat (5) @(posedge clk);
        #1 hst_cs_n = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int t0, r0, w0, d0;
        rxq.push_back(32'hA1B2C3D4);
        rxq.push_back(32'h0F1E2D3C);
        rx_refresh();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        cur_tag = "R1";
        chk(!tx_push && !rx_pop && !reg_wr && !reg_rd, "R1 no pulse", 32'(tx_push | rx_pop | reg_wr | reg_rd), 0);
        chk(!err_rx_under && !err_tx_over, "R1 flags", 32'({err_tx_over, err_rx_under}), 0);

        cur_tag = "R3";
        access(1, 0, 8'h4C, 32'h11223344, 0, 0, 1, rv);
        chk(last_rw == 32'h11223344, "R3 write unchanged", last_rw, 32'h11223344);
        chk(last_ra == 4'd3, "R7 reg index", 32'(last_ra), 3);
        cur_tag = "R4";
        access(1, 0, 8'h4C, 32'h11223344, 1, 0, 1, rv);
        chk(last_rw == 32'h44332211, "R4 write reversed", last_rw, 32'h44332211);
        cur_tag = "R3";
        access(0, 1, 8'h54, 0, 0, 0, 7, rv);
        chk(rv == bank_word(4'd5), "R3 read unchanged", rv, bank_word(4'd5));
        cur_tag = "R4";
        access(0, 1, 8'h54, 0, 1, 0, 7, rv);
        chk(rv == flip(bank_word(4'd5)), "R4 read reversed", rv, flip(bank_word(4'd5)));

        cur_tag = "R2";
        t0 = n_tx; w0 = n_rw;
        access(1, 0, 8'h4C, 32'h55AA00FF, 0, 1, 20, rv);
        chk(n_tx == t0 + 1, "R2 one push for long strobe", n_tx, t0 + 1);
        chk(n_rw == w0, "R6 no register write in fifo mode", n_rw, w0);
        chk(last_tx == 32'h55AA00FF, "R6 push data", last_tx, 32'h55AA00FF);

        cur_tag = "R6";
        r0 = n_rx; d0 = n_rr;
        access(0, 1, 8'h54, 0, 0, 1, 8, rv);
        chk(rv == 32'hA1B2C3D4, "R6 fifo read", rv, 32'hA1B2C3D4);
        chk(n_rx == r0 + 1 && n_rr == d0, "R6 pop not register", n_rx, r0 + 1);

        cur_tag = "R5";
        access(1, 0, 8'h80, 32'hDEADBEEF, 1, 1, 2, rv);
        chk(last_tx == 32'hEFBEADDE, "R5 big fifo write", last_tx, 32'hEFBEADDE);
        access(1, 0, 8'h40, 32'hCAFEF00D, 0, 0, 2, rv);
        chk(last_rw == 32'hCAFEF00D, "R5 little register write", last_rw, 32'hCAFEF00D);

        cur_tag = "R7";
        t0 = n_tx;
        access(1, 0, 8'h00, 32'h01020304, 0, 0, 1, rv);
        chk(n_tx == t0 + 1 && last_tx == 32'h01020304, "R7 data port push", last_tx, 32'h01020304);
        access(0, 1, 8'h00, 0, 1, 0, 7, rv);
        chk(rv == flip(32'h0F1E2D3C), "R7 data port pop big", rv, flip(32'h0F1E2D3C));

        cur_tag = "R8";
        access(0, 1, 8'h54, 0, 0, 0, 7, rv);
        t0 = n_tx; w0 = n_rw;
        access(1, 0, 8'h20, 32'hFFFFFFFF, 0, 0, 1, rv);
        chk(n_tx == t0 && n_rw == w0, "R8 unmapped write ignored", n_tx + n_rw, t0 + w0);
        access(0, 1, 8'h20, 0, 0, 0, 7, rv);
        chk(rv == 32'h0, "R8 unmapped read zero", rv, 0);

        cur_tag = "R9";
        r0 = n_rx;
        access(0, 1, 8'h00, 0, 0, 1, 7, rv);
        chk(rv == 32'h0, "R9 empty read zero", rv, 0);
        chk(err_rx_under == 1'b1 && n_rx == r0, "R9 underrun sticky, no pop", 32'(err_rx_under), 1);
        access(0, 1, 8'h04, 0, 0, 0, 7, rv);
        chk(rv == 32'h1, "R7 flag word bit 0", rv, 1);
        access(1, 0, 8'h04, 32'h1, 0, 0, 1, rv);
        chk(err_rx_under == 1'b0, "R7 flag clear", 32'(err_rx_under), 0);

        cur_tag = "R10";
        @(posedge clk); #1 tx_full = 1'b1;
        t0 = n_tx;
        access(1, 0, 8'h00, 32'h12345678, 0, 1, 1, rv);
        chk(n_tx == t0 && err_tx_over == 1'b1, "R10 full push dropped", 32'(err_tx_over), 1);
        access(0, 1, 8'h04, 0, 1, 0, 7, rv);
        chk(rv == 32'h02000000, "R10 flag word big endian", rv, 32'h02000000);
        @(posedge clk); #1 tx_full = 1'b0;

        cur_tag = "R11";
        @(posedge clk); #1 hst_cs_n = 1'b0;
        @(negedge clk);
        chk(hst_rdata_oe == 1'b0 && hst_rdata == 0, "R11 no drive without read", 32'(hst_rdata_oe), 0);
        @(posedge clk); #1 hst_cs_n = 1'b1; hst_rd_n = 1'b0;
        @(negedge clk);
        chk(hst_rdata_oe == 1'b0, "R11 no drive without select", 32'(hst_rdata_oe), 0);
        @(posedge clk); #1 hst_rd_n = 1'b1;
        repeat (6) @(posedge clk);

        cur_tag = "R12";
        rxq.push_back(32'h77777777);
        rx_refresh();
        t0 = n_tx; r0 = n_rx;
        access(1, 1, 8'h00, 32'h9ABCDEF0, 0, 1, 2, rv);
        chk(n_tx == t0 + 1 && last_tx == 32'h9ABCDEF0, "R12 write served", n_tx, t0 + 1);
        chk(n_rx == r0 && rxq.size() == 1, "R12 read dropped", n_rx, r0);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule